// File: doc/BRIEF.md
# Multiplexed Local Bus Master

This block is the master side of a synchronous local bus that carries address and data on one shared 32-bit lane. A simple command port accepts one access at a time. An access is either a read or a write, with one to sixteen data beats. The controller then steps the bus through four states: idle, address, data/wait and recovery. It drives the address strobe, the last-beat strobe, the direction line, the byte enables, a separate incrementing address output and the shared lane. It presents the lane as an output value plus an output enable, so the pad ring builds the tri-state buffer.

Each data beat is stretched by one of two sources. The first is an internal wait counter, reloaded at the start of every beat. The second is an external active-low ready input. A burst may be cut short by an active-low terminate input. On narrow ports (8 or 16 bits), write data is copied into every byte lane. Read data is captured from the lane, masked to the port width and returned with a one-cycle valid strobe. A done pulse marks the recovery cycle.

Top module: `mux_bus_master`

## Requirements
- R1: After reset and whenever idle, `adsN`, `blastN` and `lbeN` are all high, `adOe` is low and `cmdReady` is high.
- R2: A command accepted while `cmdReady` is high makes the next cycle the address cycle. In that cycle `adsN` is low for exactly that one cycle, `lbeN` equals `~cmdBe`, and `adOut` equals {4'b0, cmdAddr[27:2], ~cmdBe[1:0]}.
- R3: During the first data beat, `laOut` equals the command address. After each completed non-final beat it increases by the beat size: 1 for `portWidth`=2'b00, 2 for 2'b01, 4 for 2'b10 or 2'b11.
- R4: With `waitEn` high at acceptance, every beat lasts exactly `waitCnt`+1 cycles, and `readyN` has no effect.
- R5: With `waitEn` low, a beat completes in the cycle in which `readyN` is low. `beatDone` is high in exactly that cycle.
- R6: `blastN` is low in every cycle of the final beat, and high in all other cycles.
- R7: If `btermN` is low in the cycle a non-final beat completes, no further beats follow and the next cycle is recovery.
- R8: After the last beat comes a single recovery cycle with `doneP` high, then idle. `cmdReady` is high only in idle.
- R9: `lwr` (1 = write) takes the value of `cmdWrite` in the address cycle. It stays unchanged until the next command is accepted.
- R10: In write data beats, `adOut` carries `wrData` replicated. For an 8-bit port all four lanes take bits 7:0. For a 16-bit port both halves take bits 15:0. Otherwise the word passes unchanged.
- R11: `adOe` is high in the address cycle and during write data beats, and low in idle, recovery and read data beats.
- R12: For a read, `rdValid` is high in the cycle after each beat completes, and only then. `rdData` then holds the lane sampled at completion, with lanes above the port width cleared to zero.
- R13: An access has `cmdLen`+1 data beats; `cmdLen`=0 is a single transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | High in idle; command accepted when both high |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdLen | input | 4 | Number of beats minus one |
| cmdAddr | input | 28 | Start byte address |
| cmdBe | input | 4 | Byte enables, active high |
| wrData | input | 32 | Write data for the current beat |
| portWidth | input | 2 | 00 = 8-bit, 01 = 16-bit, else 32-bit |
| waitEn | input | 1 | Use internal wait counter instead of ready |
| waitCnt | input | 4 | Wait cycles per beat |
| readyN | input | 1 | External ready, active low |
| btermN | input | 1 | Burst terminate, active low |
| adsN | output | 1 | Address strobe, active low |
| blastN | output | 1 | Last-beat strobe, active low |
| lwr | output | 1 | Direction, 1 = write |
| lbeN | output | 4 | Byte enables, active low |
| laOut | output | 28 | Separate beat address |
| adOut | output | 32 | Shared lane drive value |
| adOe | output | 1 | Shared lane output enable |
| adIn | input | 32 | Shared lane sampled value |
| beatDone | output | 1 | Current beat completes this cycle |
| rdData | output | 32 | Captured read data |
| rdValid | output | 1 | Read data strobe |
| doneP | output | 1 | Recovery cycle / access finished |

## Verification
Accesses are tried with both wait sources, and each one separates different faults. Under the internal counter, random `readyN` noise exposes any leak of the external ready. Under external ready, random stall lengths show whether beat completion follows the input in the same cycle. All three port widths are crossed with single and multi-beat accesses. This tells the replication and masking lanes apart, and it also separates the address step sizes. Bursts cut short by the terminate input show whether the early exit skips the remaining beats and whether it reaches recovery without a last-beat strobe.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_RECOV = 2'd3
  } busState_t;

  localparam logic [1:0] PW_8  = 2'b00;
  localparam logic [1:0] PW_16 = 2'b01;

  typedef struct packed {
    logic loadCmd;
    logic busActive;
    logic driveAddr;
    logic driveWrite;
    logic incAddr;
    logic capRead;
  } dpStrobe_t;
endpackage

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
#(
  parameter int LENW = 4,
  parameter int WCW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic            cmdWrite,
  input  logic [LENW-1:0] cmdLen,
  input  logic            waitEn,
  input  logic [WCW-1:0]  waitCnt,
  input  logic            readyN,
  input  logic            btermN,
  output logic            cmdReady,
  output logic            adsN,
  output logic            blastN,
  output logic            lwr,
  output logic            adOe,
  output logic            beatDone,
  output logic            doneP,
  output dpStrobe_t       strobes
);
  busState_t       state;
  logic [LENW-1:0] beatsLeft;
  logic [WCW-1:0]  waitCtr;
  logic [WCW-1:0]  cfgWaitCnt;
  logic            cfgWaitEn;
  logic            dirWrite;
  logic            lastBeat;
  logic            endNow;

  assign lastBeat = (beatsLeft == '0);
  assign beatDone = (state == ST_DATA) &&
                    (cfgWaitEn ? (waitCtr == '0) : !readyN);
  assign endNow   = lastBeat || !btermN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatsLeft  <= '0;
      waitCtr    <= '0;
      cfgWaitCnt <= '0;
      cfgWaitEn  <= 1'b0;
      dirWrite   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            state      <= ST_ADDR;
            dirWrite   <= cmdWrite;
            beatsLeft  <= cmdLen;
            cfgWaitEn  <= waitEn;
            cfgWaitCnt <= waitCnt;
          end
        end
        ST_ADDR: begin
          state   <= ST_DATA;
          waitCtr <= cfgWaitCnt;
        end
        ST_DATA: begin
          if (beatDone) begin
            if (endNow) begin
              state <= ST_RECOV;
            end else begin
              beatsLeft <= beatsLeft - 1'b1;
              waitCtr   <= cfgWaitCnt;
            end
          end else if (waitCtr != '0) begin
            waitCtr <= waitCtr - 1'b1;
          end
        end
        ST_RECOV: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign cmdReady = (state == ST_IDLE);
  assign adsN     = !(state == ST_ADDR);
  assign blastN   = !((state == ST_DATA) && lastBeat);
  assign lwr      = dirWrite;
  assign doneP    = (state == ST_RECOV);
  assign adOe     = (state == ST_ADDR) || ((state == ST_DATA) && dirWrite);

  always_comb begin
    strobes            = '0;
    strobes.loadCmd    = (state == ST_IDLE) && cmdValid;
    strobes.busActive  = (state == ST_ADDR) || (state == ST_DATA);
    strobes.driveAddr  = (state == ST_ADDR);
    strobes.driveWrite = (state == ST_DATA) && dirWrite;
    strobes.incAddr    = beatDone && !endNow;
    strobes.capRead    = beatDone && !dirWrite;
  end

  // R2
  ads_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |=> adsN);
  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> (cmdReady && !doneP));
  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |=> $stable(lwr));
  // R6
  blast_in_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blastN |-> (adsN && !cmdReady && !doneP));
  // R11
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!adsN || lwr));
endmodule

// File: rtl/mbm_datapath.sv
module mbm_datapath
  import mbm_pkg::*;
#(
  parameter int AW = 28,
  parameter int DW = 32,
  parameter int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobes,
  input  logic [AW-1:0]  cmdAddr,
  input  logic [BEW-1:0] cmdBe,
  input  logic [1:0]     portWidth,
  input  logic [DW-1:0]  wrData,
  input  logic [DW-1:0]  adIn,
  output logic [AW-1:0]  laOut,
  output logic [BEW-1:0] lbeN,
  output logic [DW-1:0]  adOut,
  output logic [DW-1:0]  rdData,
  output logic           rdValid
);
  localparam int LANES = DW / 8;

  logic [AW-1:0]  addrReg;
  logic [BEW-1:0] beNReg;
  logic [1:0]     widthReg;
  logic [AW-1:0]  step;
  logic [3:0]     laneCount;
  logic [DW-1:0]  repData;
  logic [DW-1:0]  rdMasked;

  always_comb begin
    unique case (widthReg)
      PW_8:    begin step = AW'(1); laneCount = 4'd1; end
      PW_16:   begin step = AW'(2); laneCount = 4'd2; end
      default: begin step = AW'(4); laneCount = 4'd4; end
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign repData[i*8 +: 8] = (widthReg == PW_8)  ? wrData[7:0] :
                               (widthReg == PW_16) ? wrData[(i%2)*8 +: 8] :
                                                     wrData[i*8 +: 8];
    assign rdMasked[i*8 +: 8] = (4'(i) < laneCount) ? adIn[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      beNReg   <= '1;
      widthReg <= 2'b10;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobes.loadCmd) begin
        addrReg  <= cmdAddr;
        beNReg   <= ~cmdBe;
        widthReg <= portWidth;
      end else if (strobes.incAddr) begin
        addrReg <= addrReg + step;
      end
      rdValid <= strobes.capRead;
      if (strobes.capRead) rdData <= rdMasked;
    end
  end

  assign laOut = addrReg;
  assign lbeN  = strobes.busActive ? beNReg : '1;
  assign adOut = strobes.driveAddr  ? {{(DW-AW){1'b0}}, addrReg[AW-1:2], beNReg[1:0]} :
                 strobes.driveWrite ? repData : '0;

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incAddr |=> (laOut == $past(laOut) + $past(step)));
  // R10
  byte_repl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.driveWrite && widthReg == PW_8) |-> (adOut[DW-1:DW-8] == adOut[7:0]));
  // R12
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capRead |=> rdValid);
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int AW   = 28,
  parameter int DW   = 32,
  parameter int LENW = 4,
  parameter int WCW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic            cmdWrite,
  input  logic [LENW-1:0] cmdLen,
  input  logic [AW-1:0]   cmdAddr,
  input  logic [DW/8-1:0] cmdBe,
  input  logic [DW-1:0]   wrData,
  input  logic [1:0]      portWidth,
  input  logic            waitEn,
  input  logic [WCW-1:0]  waitCnt,
  input  logic            readyN,
  input  logic            btermN,
  output logic            adsN,
  output logic            blastN,
  output logic            lwr,
  output logic [DW/8-1:0] lbeN,
  output logic [AW-1:0]   laOut,
  output logic [DW-1:0]   adOut,
  output logic            adOe,
  input  logic [DW-1:0]   adIn,
  output logic            beatDone,
  output logic [DW-1:0]   rdData,
  output logic            rdValid,
  output logic            doneP
);
  dpStrobe_t strobes;

  mbm_ctrl #(.LENW(LENW), .WCW(WCW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdLen(cmdLen), .waitEn(waitEn), .waitCnt(waitCnt), .readyN(readyN),
    .btermN(btermN), .cmdReady(cmdReady), .adsN(adsN), .blastN(blastN),
    .lwr(lwr), .adOe(adOe), .beatDone(beatDone), .doneP(doneP),
    .strobes(strobes)
  );

  mbm_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdAddr(cmdAddr),
    .cmdBe(cmdBe), .portWidth(portWidth), .wrData(wrData), .adIn(adIn),
    .laOut(laOut), .lbeN(lbeN), .adOut(adOut), .rdData(rdData),
    .rdValid(rdValid)
  );
endmodule

// File: tb/tb_mux_bus_master.sv
module tb_mux_bus_master;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid, cmdReady, cmdWrite;
  logic [3:0]  cmdLen;
  logic [27:0] cmdAddr;
  logic [3:0]  cmdBe;
  logic [31:0] wrData;
  logic [1:0]  portWidth;
  logic        waitEn;
  logic [3:0]  waitCnt;
  logic        readyN, btermN;
  logic        adsN, blastN, lwr, adOe, beatDone, rdValid, doneP;
  logic [3:0]  lbeN;
  logic [27:0] laOut;
  logic [31:0] adOut, adIn, rdData;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  mux_bus_master dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdLen(cmdLen), .cmdAddr(cmdAddr), .cmdBe(cmdBe),
    .wrData(wrData), .portWidth(portWidth), .waitEn(waitEn), .waitCnt(waitCnt),
    .readyN(readyN), .btermN(btermN), .adsN(adsN), .blastN(blastN), .lwr(lwr),
    .lbeN(lbeN), .laOut(laOut), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .beatDone(beatDone), .rdData(rdData), .rdValid(rdValid), .doneP(doneP)
  );

  task automatic chkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  function automatic logic [31:0] replExp(logic [1:0] w, logic [31:0] d);
    if (w == 2'b00) return {4{d[7:0]}};
    if (w == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] maskExp(logic [1:0] w, logic [31:0] d);
    if (w == 2'b00) return {24'h0, d[7:0]};
    if (w == 2'b01) return {16'h0, d[15:0]};
    return d;
  endfunction

  function automatic logic [27:0] stepExp(logic [1:0] w);
    if (w == 2'b00) return 28'd1;
    if (w == 2'b01) return 28'd2;
    return 28'd4;
  endfunction

  // Called at a negedge while idle.
  task automatic runTxn(bit wr, int nb, logic [27:0] a, logic [3:0] be,
                        logic [1:0] w, bit we, int wc, int termAt);
    logic [27:0] expA;
    logic [31:0] wd, rv, pendVal;
    bit pend, stopped, isLast, expDone, term;
    int cyc;
    cmdValid = 1; cmdWrite = wr; cmdLen = 4'(nb - 1); cmdAddr = a; cmdBe = be;
    portWidth = w; waitEn = we; waitCnt = 4'(wc); readyN = 1; btermN = 1;
    #1;
    chkEq("R8 cmdReady in idle", {31'b0, cmdReady}, 32'd1);
    @(negedge clk);
    cmdValid = 0; cmdAddr = 28'($urandom); cmdBe = 4'($urandom);
    portWidth = 2'($urandom); waitEn = 1'($urandom); waitCnt = 4'($urandom);
    #1;
    chkEq("R2 adsN low in address cycle", {31'b0, adsN}, 32'd0);
    chkEq("R2 adOut address", adOut, {4'b0, a[27:2], ~be[1:0]});
    chkEq("R2 lbeN", {28'b0, lbeN}, {28'b0, ~be});
    chkEq("R11 adOe in address cycle", {31'b0, adOe}, 32'd1);
    chkEq("R9 lwr in address cycle", {31'b0, lwr}, {31'b0, wr});
    @(negedge clk);
    expA = a; pend = 0; stopped = 0; pendVal = '0;
    for (int b = 0; b < nb; b++) begin
      wd = $urandom; rv = $urandom; wrData = wd; adIn = rv; cyc = 0;
      isLast = (b == nb - 1);
      expDone = 0;
      while (!expDone) begin
        if (we) begin
          readyN  = 1'($urandom);
          expDone = (cyc == wc);
        end else begin
          readyN  = (cyc >= 4 || ($urandom % 3) == 0) ? 1'b0 : 1'b1;
          expDone = !readyN;
        end
        term   = expDone && (b == termAt);
        btermN = term ? 1'b0 : 1'b1;
        #1;
        if (pend) begin
          chkEq("R12 rdValid after beat", {31'b0, rdValid}, 32'd1);
          chkEq("R12 rdData masked", rdData, maskExp(w, pendVal));
          pend = 0;
        end else begin
          chkEq("R12 rdValid idle", {31'b0, rdValid}, 32'd0);
        end
        chkEq(we ? "R4 beatDone from counter" : "R5 beatDone from ready",
              {31'b0, beatDone}, {31'b0, expDone});
        chkEq("R3 laOut", {4'b0, laOut}, {4'b0, expA});
        chkEq("R6 blastN", {31'b0, blastN}, {31'b0, !isLast});
        chkEq("R11 adOe in data", {31'b0, adOe}, {31'b0, wr});
        if (wr) chkEq("R10 write lanes", adOut, replExp(w, wd));
        @(negedge clk);
        cyc++;
      end
      if (!wr) begin pend = 1; pendVal = rv; end
      expA = expA + stepExp(w);
      if (term && !isLast) begin stopped = 1; break; end
    end
    readyN = 1; btermN = 1;
    #1;
    if (pend) begin
      chkEq("R12 rdValid last beat", {31'b0, rdValid}, 32'd1);
      chkEq("R12 rdData last beat", rdData, maskExp(w, pendVal));
    end
    chkEq(stopped ? "R7 recovery after terminate" : "R8 R13 recovery after final beat",
          {31'b0, doneP}, 32'd1);
    chkEq("R11 adOe in recovery", {31'b0, adOe}, 32'd0);
    chkEq("R8 cmdReady low in recovery", {31'b0, cmdReady}, 32'd0);
    chkEq("R9 lwr held", {31'b0, lwr}, {31'b0, wr});
    @(negedge clk);
    #1;
    chkEq("R1 idle cmdReady", {31'b0, cmdReady}, 32'd1);
    chkEq("R1 idle strobes", {28'b0, adsN, blastN, adOe, doneP}, 32'b1100);
    chkEq("R1 idle lbeN", {28'b0, lbeN}, 32'hF);
    chkEq("R9 lwr kept in idle", {31'b0, lwr}, {31'b0, wr});
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; cmdValid = 0; cmdWrite = 0; cmdLen = 0; cmdAddr = 0; cmdBe = 0;
    wrData = 0; portWidth = 2'b10; waitEn = 0; waitCnt = 0; readyN = 1;
    btermN = 1; adIn = 0;
    repeat (3) @(negedge clk);
    #1;
    chkEq("R1 reset cmdReady", {31'b0, cmdReady}, 32'd1);
    chkEq("R1 reset strobes", {28'b0, adsN, blastN, adOe, doneP}, 32'b1100);
    chkEq("R1 reset lbeN", {28'b0, lbeN}, 32'hF);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // Directed corners
    runTxn(1, 1,  28'h000_1234, 4'hF, 2'b10, 0, 0, -1);   // R13 single write
    runTxn(0, 1,  28'h0AB_CDE3, 4'h1, 2'b00, 1, 3, -1);   // R4 R12 narrow read
    runTxn(1, 4,  28'h100_0000, 4'h3, 2'b01, 0, 0, -1);   // R10 16-bit burst
    runTxn(0, 16, 28'hFFF_FFF0, 4'hF, 2'b10, 1, 2, -1);   // R13 longest burst
    runTxn(1, 8,  28'h020_0000, 4'hF, 2'b00, 0, 0, 1);    // R7 terminate early
    runTxn(0, 5,  28'h030_0004, 4'hC, 2'b11, 1, 0, 3);    // R7 with counter
    runTxn(1, 2,  28'h040_0002, 4'h6, 2'b10, 1, 15, -1);  // R4 max wait
    runTxn(0, 3,  28'h050_0001, 4'h2, 2'b01, 1, 0, 2);    // terminate on last beat
    // Random mix
    for (int k = 0; k < 40; k++) begin
      runTxn(1'($urandom), 1 + ($urandom % 16), 28'($urandom), 4'($urandom),
             2'($urandom), 1'($urandom), $urandom % 6,
             (($urandom % 3) == 0) ? int'($urandom % 16) : -1);
    end
    summary();
    $finish;
  end
endmodule